// File: doc/BRIEF.md
# Receive Character Queue with Error Summary

This block sits between a serial receiver's deserializer and the host side of a UART. Each time the receiver finishes a character it strobes the byte in together with three per-character status bits: parity error, framing error and break. The block queues these entries in arrival order. The host pops them one at a time and sees the byte and its status at the head of the queue.

Besides the usual empty, full and fill-level outputs, the block raises one summary flag whenever any entry still waiting in the queue carries an error bit. The entry does not have to be at the head. A running tally of bad entries drives the flag, so it drops by itself in the cycle after the last bad entry is popped, with no scan of the storage. A push that finds no free slot is discarded and recorded in a sticky overrun bit. The host clears that bit with a read strobe.

Top module: `rx_err_fifo`

## Requirements
- R1: After a synchronous reset, `empty` is 1, `full` is 0, `level` is 0, `err_any` is 0 and `overrun` is 0.
- R2: Entries leave in the order they arrived. The head is presented combinationally on `head_data` and `head_stat`, with `head_stat` bit 0 = parity error, bit 1 = framing error and bit 2 = break. It changes in the cycle after the push or pop that updates it.
- R3: `err_any` is 1 whenever at least one stored entry has any status bit set, wherever that entry sits in the queue.
- R4: `err_any` returns to 0 in the cycle after the last stored entry with a status bit set is popped. It stays 1 while any such entry remains.
- R5: A push and a pop in the same cycle on a non-empty queue both take effect. `level` is unchanged, and the count of bad entries rises for the pushed entry and falls for the popped one.
- R6: A push while the queue is full and no pop is requested is discarded. The stored contents do not change, and `overrun` becomes 1 and stays 1.
- R7: A pulse on `ovr_rd` clears `overrun` in the next cycle. If a discarded push happens in the same cycle, `overrun` stays 1.
- R8: A pop while the queue is empty has no effect on `level` or `err_any`. While the queue is empty, `head_data` and `head_stat` are 0.
- R9: `level` gives the number of stored entries (0 to DEPTH, default DEPTH = 16). `full` is 1 exactly when `level` equals DEPTH, and `empty` is 1 exactly when `level` is 0.
- R10: A push in the same cycle as a pop on a full queue is accepted. The popped slot is reused, and `overrun` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push | input | 1 | Receiver strobe: store one entry |
| push_data | input | 8 | Received byte |
| push_stat | input | 3 | Status of the byte: bit0 parity, bit1 framing, bit2 break |
| pop | input | 1 | Host strobe: remove the head entry |
| ovr_rd | input | 1 | Host read of the overrun bit; clears it |
| head_data | output | 8 | Byte at the head, 0 when empty |
| head_stat | output | 3 | Status at the head, 0 when empty |
| err_any | output | 1 | Some stored entry carries an error bit |
| empty | output | 1 | No entries stored |
| full | output | 1 | All DEPTH slots used |
| level | output | 5 | Number of stored entries |
| overrun | output | 1 | Sticky: a push was discarded |

## Verification
The hardest situation to reach is one where the bad-entry tally must stay unchanged while its contents turn over: a same-cycle push and pop where both entries are bad, and a full queue that takes a push and a pop together. The vector table reaches the first case by queueing a framing-error byte and then replacing it with a break byte in a single cycle. The directed part fills all sixteen slots with only the newest entry bad, then exercises overrun, the clear strobe and the simultaneous case at full. It then drains the queue and checks that `err_any` stays high until the bad entry leaves from the far end.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int DATA_W = 8;
    localparam int STAT_W = 3;

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } rxq_stat_t;

    typedef struct packed {
        rxq_stat_t              stat;
        logic [DATA_W-1:0]      data;
    } rxq_entry_t;

    localparam int ENTRY_W = $bits(rxq_entry_t);

    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_POP  = 2'b01,
        OP_PUSH = 2'b10,
        OP_BOTH = 2'b11
    } rxq_op_t;

    function automatic logic entry_bad(rxq_entry_t e);
        return e.stat.brk | e.stat.frm | e.stat.par;
    endfunction

endpackage

// File: rtl/rxq_ptr_ctrl.sv
module rxq_ptr_ctrl #(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_req,
    input  logic          rd_req,
    output logic          do_push,
    output logic          do_pop,
    output logic          dropped,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] fill,
    output logic          is_full,
    output logic          is_empty
);
    import rxq_pkg::*;

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

    rxq_op_t op;

    assign is_empty = (fill == '0);
    assign is_full  = (fill == FULL_LVL);
    assign do_pop   = rd_req & ~is_empty;
    assign do_push  = wr_req & (~is_full | do_pop);
    assign dropped  = wr_req & ~do_push;
    assign op       = rxq_op_t'({do_push, do_pop});

    function automatic logic [AW-1:0] step(logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            unique case (op)
                OP_PUSH: begin
                    wr_ptr <= step(wr_ptr);
                    fill   <= fill + CW'(1);
                end
                OP_POP: begin
                    rd_ptr <= step(rd_ptr);
                    fill   <= fill - CW'(1);
                end
                OP_BOTH: begin
                    wr_ptr <= step(wr_ptr);
                    rd_ptr <= step(rd_ptr);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                clk,
    input  logic                we,
    input  logic [AW-1:0]       waddr,
    input  rxq_pkg::rxq_entry_t wentry,
    input  logic [AW-1:0]       raddr,
    output rxq_pkg::rxq_entry_t rentry
);
    import rxq_pkg::*;

    rxq_entry_t slot [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we && (waddr == AW'(g))) begin
                slot[g] <= wentry;
            end
        end
    end

    assign rentry = slot[raddr];

endmodule

// File: rtl/rxq_err_track.sv
module rxq_err_track #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic add_ok,
    input  logic add_bad,
    input  logic sub_ok,
    input  logic sub_bad,
    output logic flag
);
    logic [CW-1:0] bad_cnt;
    logic          inc, dec;

    assign inc = add_ok & add_bad;
    assign dec = sub_ok & sub_bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            bad_cnt <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   bad_cnt <= bad_cnt + CW'(1);
                2'b01:   bad_cnt <= bad_cnt - CW'(1);
                default: bad_cnt <= bad_cnt;
            endcase
        end
    end

    assign flag = (bad_cnt != '0);

endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo #(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [7:0]    push_data,
    input  logic [2:0]    push_stat,
    input  logic          pop,
    input  logic          ovr_rd,
    output logic [7:0]    head_data,
    output logic [2:0]    head_stat,
    output logic          err_any,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] level,
    output logic          overrun
);
    import rxq_pkg::*;

    rxq_entry_t    in_e, head_e, shown_e;
    logic          do_push, do_pop, dropped;
    logic [AW-1:0] wr_ptr, rd_ptr;

    assign in_e.data = push_data;
    assign in_e.stat = rxq_stat_t'(push_stat);

    rxq_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .wr_req   (push),
        .rd_req   (pop),
        .do_push  (do_push),
        .do_pop   (do_pop),
        .dropped  (dropped),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .fill     (level),
        .is_full  (full),
        .is_empty (empty)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .we     (do_push),
        .waddr  (wr_ptr),
        .wentry (in_e),
        .raddr  (rd_ptr),
        .rentry (head_e)
    );

    rxq_err_track #(.DEPTH(DEPTH)) u_err (
        .clk     (clk),
        .rst     (rst),
        .add_ok  (do_push),
        .add_bad (entry_bad(in_e)),
        .sub_ok  (do_pop),
        .sub_bad (entry_bad(head_e)),
        .flag    (err_any)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            overrun <= 1'b0;
        end else if (dropped) begin
            overrun <= 1'b1;
        end else if (ovr_rd) begin
            overrun <= 1'b0;
        end
    end

    assign shown_e   = empty ? '0 : head_e;
    assign head_data = shown_e.data;
    assign head_stat = shown_e.stat;

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          push,
    input logic          pop,
    input logic          ovr_rd,
    input logic [7:0]    head_data,
    input logic [2:0]    head_stat,
    input logic          err_any,
    input logic          empty,
    input logic          full,
    input logic [CW-1:0] level,
    input logic          overrun
);
    // R3
    err_needs_entry_chk: assert property (@(posedge clk) disable iff (rst)
        err_any |-> !empty);

    // R9
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        level <= CW'(DEPTH));

    // R6
    drop_sets_ovr_chk: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> overrun);

    // R6
    drop_keeps_level_chk: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> $stable(level));

    // R8
    empty_pop_still_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> ($stable(level) && $stable(err_any)));

    // R8
    empty_head_zero_chk: assert property (@(posedge clk) disable iff (rst)
        empty |-> (head_data == 8'h00 && head_stat == 3'b000));

    // R5
    both_keeps_level_chk: assert property (@(posedge clk) disable iff (rst)
        (push && pop && !empty) |=> $stable(level));

    // R7
    ovr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ovr_rd && !(push && full && !pop)) |=> !overrun);

    // R4
    clean_pop_keeps_err_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && !empty && head_stat == 3'b000) |=> $stable(err_any));

endmodule

bind rx_err_fifo rxq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .pop       (pop),
    .ovr_rd    (ovr_rd),
    .head_data (head_data),
    .head_stat (head_stat),
    .err_any   (err_any),
    .empty     (empty),
    .full      (full),
    .level     (level),
    .overrun   (overrun)
);

// File: tb/sim_rx_err_fifo.sv
`timescale 1ns/1ps
module sim_rx_err_fifo;

    logic       clk = 1'b0;
    logic       rst;
    logic       push, pop, ovr_rd;
    logic [7:0] push_data;
    logic [2:0] push_stat;
    logic [7:0] head_data;
    logic [2:0] head_stat;
    logic       err_any, empty, full, overrun;
    logic [4:0] level;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    rx_err_fifo u0 (
        .clk(clk), .rst(rst), .push(push), .push_data(push_data),
        .push_stat(push_stat), .pop(pop), .ovr_rd(ovr_rd),
        .head_data(head_data), .head_stat(head_stat), .err_any(err_any),
        .empty(empty), .full(full), .level(level), .overrun(overrun)
    );

    // {op[1]=push op[0]=pop, data, stat, exp level, exp err_any, exp {stat,data} at head}
    localparam int NV = 11;
    localparam logic [29:0] VEC [NV] = '{
        {2'b10, 8'hA5, 3'b000, 5'd1, 1'b0, 11'h0A5},
        {2'b10, 8'h3C, 3'b001, 5'd2, 1'b1, 11'h0A5},
        {2'b10, 8'h0F, 3'b000, 5'd3, 1'b1, 11'h0A5},
        {2'b01, 8'h00, 3'b000, 5'd2, 1'b1, 11'h13C},
        {2'b01, 8'h00, 3'b000, 5'd1, 1'b0, 11'h00F},
        {2'b11, 8'h81, 3'b010, 5'd1, 1'b1, 11'h281},
        {2'b11, 8'h22, 3'b100, 5'd1, 1'b1, 11'h422},
        {2'b01, 8'h00, 3'b000, 5'd0, 1'b0, 11'h000},
        {2'b01, 8'h00, 3'b000, 5'd0, 1'b0, 11'h000},
        {2'b10, 8'h55, 3'b011, 5'd1, 1'b1, 11'h355},
        {2'b01, 8'h00, 3'b000, 5'd0, 1'b0, 11'h000}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // called at a negedge; applies one cycle of stimulus, returns at the next negedge
    task automatic cyc(logic p, logic q, logic [7:0] d, logic [2:0] s, logic o);
        push = p; pop = q; push_data = d; push_stat = s; ovr_rd = o;
        @(negedge clk);
        push = 0; pop = 0; push_data = 0; push_stat = 0; ovr_rd = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        rst = 1; push = 0; pop = 0; push_data = 0; push_stat = 0; ovr_rd = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        check("R1 empty", empty, 1);
        check("R1 full", full, 0);
        check("R1 level", level, 0);
        check("R1 err_any", err_any, 0);
        check("R1 overrun", overrun, 0);

        // table walk: R2 order, R3/R4 flag, R5 simultaneous, R8 empty pop
        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i][29], VEC[i][28], VEC[i][27:20], VEC[i][19:17], 0);
            check("R9 level", level, VEC[i][16:12]);
            check("R3 R4 err_any", err_any, VEC[i][11]);
            check("R2 R8 head", {head_stat, head_data}, VEC[i][10:0]);
        end

        // fill: only the newest (16th) entry is bad
        for (int k = 0; k < 16; k++)
            cyc(1, 0, 8'(k + 1), (k == 15) ? 3'b100 : 3'b000, 0);
        check("R9 full", full, 1);
        check("R9 level16", level, 16);
        check("R3 far entry", err_any, 1);
        check("R6 no ovr yet", overrun, 0);

        // R6 discarded push
        cyc(1, 0, 8'hEE, 3'b001, 0);
        check("R6 overrun", overrun, 1);
        check("R6 level", level, 16);
        check("R6 head", head_data, 8'h01);
        cyc(0, 0, 0, 0, 0);
        check("R6 sticky", overrun, 1);

        // R7 clear and set-wins
        cyc(1, 0, 8'hEE, 3'b000, 1);
        check("R7 set wins", overrun, 1);
        cyc(0, 0, 0, 0, 1);
        check("R7 cleared", overrun, 0);

        // R10 push+pop at full
        cyc(1, 1, 8'hF0, 3'b000, 0);
        check("R10 level", level, 16);
        check("R10 no ovr", overrun, 0);
        check("R10 head", head_data, 8'h02);

        // drain: entries 2..16 then F0; flag stays until bad entry 16 leaves
        for (int k = 2; k <= 16; k++) begin
            check("R2 drain order", head_data, k);
            check("R4 flag held", err_any, 1);
            cyc(0, 1, 0, 0, 0);
        end
        check("R4 flag drops", err_any, 0);
        check("R2 last", head_data, 8'hF0);
        cyc(0, 1, 0, 0, 0);
        check("R9 empty", empty, 1);

        // R1 reset with content
        cyc(1, 0, 8'h77, 3'b010, 0);
        rst = 1;
        @(negedge clk);
        rst = 0;
        check("R1 reset level", level, 0);
        check("R1 reset err", err_any, 0);
        check("R1 reset head", {head_stat, head_data}, 0);

        finish_run();
    end

endmodule